// File: doc/BRIEF.md
# NOR flash command and status controller

A behavioural controller for a byte-wide NOR flash array. The host drives active-low chip enable, write enable and output enable strobes together with a 19-bit byte address and an 8-bit data bus; all strobes are sampled on the system clock. A write is taken on the rising edge of write enable while chip enable is low. A read is taken on the falling edge of output enable while chip enable is low. Unlocked command writes start an internal program or erase algorithm. While such an algorithm runs, reads return a status byte in place of array data, so the host can poll for completion.

The array is split into eight sectors chosen by the top three address bits. Each sector can be protected by a static input, which blocks both programming and erasing of that sector. A sector erase collects sectors during a short window. It then runs a preprogram pass followed by an erase pass over the selected sectors. The erase can be suspended so that other sectors can be read or programmed, and then resumed. The model stores a reduced sector size: the offset width is a parameter, 6 bits by default, giving 64 bytes per sector.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF and data_o is 0x00. A read loads data_o on the clock edge that first samples oe_ni low while ce_ni is low and we_ni is high.
- R2: The sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@address programs one byte. Command addresses compare address bits 15:0. The new byte is the old byte AND the data, so only 1→0 changes occur. The operation is busy for PROG_CYC cycles.
- R3: A write that breaks the unlock sequence, or a 0xF0 write before the last command byte, returns the decoder to read mode. The bytes that follow are not taken as a command.
- R4: A status read while busy returns bit 7 as the complement of the programmed data's bit 7 during a program, and as 0 during an erase. Bits 5:3 and 1:0 read 0. Bit 2 reads 0 during a plain program. Once the operation ends, reads return the true array byte.
- R5: Bit 6 of the status byte inverts on every status read made while an operation is busy.
- R6: Bit 2 inverts on every read of an erase-selected sector during an erase, including its collection window, and while the erase is suspended. Reads of other sectors leave it unchanged.
- R7: The erase sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30@sector address selects that sector. Further 0x30 writes within WIN_CYC cycles of the last one add their sectors. Selected sectors end at 0xFF and all other sectors are unchanged.
- R8: Replacing the last erase byte with 0x10@0x555 erases every unprotected sector.
- R9: A 0xB0 write during an erase pass suspends it. While suspended, reads of unselected sectors return array data. Reads of selected sectors return status with bit 7 = 1 and bit 6 held. A 0x30 write with the decoder idle resumes the erase.
- R10: While suspended, the program sequence works on unselected, unprotected sectors. A program to an erase-selected sector starts no operation.
- R11: A set bit in prot_i (bit n = sector n) blocks programming and erasing of that sector. An erase that would select only protected sectors starts no operation.
- R12: The sector is address bits 18:16 and the byte offset is the low OFF_W bits. Address bits between them are ignored for array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; write taken on its rising edge |
| oe_ni | input | 1 | Output enable, active low; read taken on its falling edge |
| addr_i | input | 19 | Byte address |
| data_i | input | 8 | Write data or command byte |
| prot_i | input | 8 | Per-sector protection, bit n protects sector n |
| data_o | output | 8 | Registered read result: array byte or status |

## Verification
Programming is tried with a byte that has bit 7 clear, so data polling shows a 1 while busy. A second program over the same byte shows that only bits are cleared. Corrupted and 0xF0-interrupted unlock sequences must leave the array untouched, which separates a decoder that restarts from one that resumes mid-sequence. The erase runs with two sectors collected in the window. Polls alternate between selected and unselected sectors, which tells the two toggle bits apart. A suspend/program/resume pass shows that the unselected sector keeps its new value while both selected sectors end erased. Chip erase with one sector protected separates the protection mask from the selection logic.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    E_IDLE, E_PROG, E_WIN, E_PRE, E_ERS, E_SUSP, E_SPROG
  } eng_state_e;

  typedef enum logic [2:0] {
    D_IDLE, D_U1, D_U2, D_E1, D_E2, D_E3, D_PDATA
  } dec_state_e;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ESET  = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SUSP  = 8'hB0;
  localparam logic [7:0] CMD_RST   = 8'hF0;
endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec import flash_pkg::*; #(
  parameter int CA_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            wr_stb_i,
  input  logic [CA_W-1:0] addr_i,
  input  logic [7:0]      data_i,
  output logic            prog_o,
  output logic            chip_o,
  output logic            sect_o,
  output logic            idle_o
);
  localparam logic [CA_W-1:0] ADR_A = CA_W'('h555);
  localparam logic [CA_W-1:0] ADR_B = CA_W'('h2AA);

  dec_state_e st_q;
  logic at_a, at_b, fire;

  assign at_a = (addr_i == ADR_A);
  assign at_b = (addr_i == ADR_B);
  assign fire = enable_i && wr_stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= D_IDLE;
    end else if (!enable_i) begin
      st_q <= D_IDLE;
    end else if (wr_stb_i) begin
      if (data_i == CMD_RST && st_q != D_PDATA) begin
        st_q <= D_IDLE;
      end else begin
        case (st_q)
          D_IDLE: st_q <= (data_i == CMD_UNLK1 && at_a) ? D_U1 : D_IDLE;
          D_U1:   st_q <= (data_i == CMD_UNLK2 && at_b) ? D_U2 : D_IDLE;
          D_U2: begin
            if (data_i == CMD_PROG && at_a)      st_q <= D_PDATA;
            else if (data_i == CMD_ESET && at_a) st_q <= D_E1;
            else                                 st_q <= D_IDLE;
          end
          D_E1:   st_q <= (data_i == CMD_UNLK1 && at_a) ? D_E2 : D_IDLE;
          D_E2:   st_q <= (data_i == CMD_UNLK2 && at_b) ? D_E3 : D_IDLE;
          default: st_q <= D_IDLE;
        endcase
      end
    end
  end

  assign prog_o = fire && st_q == D_PDATA;
  assign chip_o = fire && st_q == D_E3 && data_i == CMD_CHIP && at_a;
  assign sect_o = fire && st_q == D_E3 && data_i == CMD_SECT;
  assign idle_o = (st_q == D_IDLE);

  // R3: an abort byte always lands in read mode
  p_f0_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && data_i == CMD_RST && st_q != D_PDATA) |=> st_q == D_IDLE);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_idx_i,
  output logic [7:0]    rd_o,
  input  logic          wr_en_i,
  input  logic          wr_and_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [7:0]    wr_d_i
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_and_i ? (mem_q[wr_idx_i] & wr_d_i) : wr_d_i;
    end
  end

  assign rd_o = mem_q[rd_idx_i];
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine import flash_pkg::*; #(
  parameter int SECTORS  = 8,
  parameter int OFF_W    = 6,
  parameter int PROG_CYC = 8,
  parameter int WIN_CYC  = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_stb_i,
  input  logic [7:0]                        wr_data_i,
  input  logic [$clog2(SECTORS)-1:0]        wr_sec_i,
  input  logic [OFF_W-1:0]                  wr_off_i,
  input  logic                              prog_cmd_i,
  input  logic                              chip_cmd_i,
  input  logic                              sect_cmd_i,
  input  logic                              dec_idle_i,
  input  logic [SECTORS-1:0]                prot_i,
  output eng_state_e                        state_o,
  output logic [SECTORS-1:0]                sel_o,
  output logic                              pd7_o,
  output logic                              dec_en_o,
  output logic                              arr_we_o,
  output logic                              arr_and_o,
  output logic [$clog2(SECTORS)+OFF_W-1:0]  arr_idx_o,
  output logic [7:0]                        arr_d_o
);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int ARR_AW = SEC_W + OFF_W;
  localparam int MAXC   = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
  localparam int CNT_W  = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);

  eng_state_e         st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SECTORS-1:0] sel_q, sect_m, chip_m;
  logic [ARR_AW-1:0]  pa_q, cur_q, wr_idx;
  logic [7:0]         pd_q;
  logic               ph_q;
  logic [SEC_W-1:0]   cur_sec;
  logic               cur_last, susp_cmd, add_cmd, prog_ok, prog_end;

  assign wr_idx   = {wr_sec_i, wr_off_i};
  assign cur_sec  = cur_q[ARR_AW-1 -: SEC_W];
  assign cur_last = &cur_q;
  assign susp_cmd = wr_stb_i && wr_data_i == CMD_SUSP;
  assign add_cmd  = wr_stb_i && wr_data_i == CMD_SECT;
  assign prog_end = cnt_q == PROG_LAST;
  assign chip_m   = ~prot_i;
  assign prog_ok  = prog_cmd_i && !prot_i[wr_sec_i] &&
                    (st_q == E_IDLE || (st_q == E_SUSP && !sel_q[wr_sec_i]));

  always_comb begin
    for (int i = 0; i < SECTORS; i++)
      sect_m[i] = (wr_sec_i == SEC_W'(i)) && !prot_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= E_IDLE;
      cnt_q <= '0;
      sel_q <= '0;
      pa_q  <= '0;
      pd_q  <= '0;
      cur_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      case (st_q)
        E_IDLE: begin
          if (prog_ok) begin
            st_q <= E_PROG; pa_q <= wr_idx; pd_q <= wr_data_i; cnt_q <= '0;
          end else if (chip_cmd_i && |chip_m) begin
            st_q <= E_PRE; sel_q <= chip_m; cur_q <= '0;
          end else if (sect_cmd_i && |sect_m) begin
            st_q <= E_WIN; sel_q <= sect_m; cnt_q <= '0;
          end
        end
        E_PROG, E_SPROG: begin
          if (prog_end) st_q <= (st_q == E_PROG) ? E_IDLE : E_SUSP;
          else          cnt_q <= cnt_q + 1'b1;
        end
        E_WIN: begin
          if (add_cmd) begin
            sel_q <= sel_q | sect_m; cnt_q <= '0;
          end else if (cnt_q == WIN_LAST) begin
            st_q <= E_PRE; cur_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        E_PRE: begin
          if (susp_cmd) begin
            st_q <= E_SUSP; ph_q <= 1'b0;
          end else if (cur_last) begin
            st_q <= E_ERS; cur_q <= '0;
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        E_ERS: begin
          if (susp_cmd) begin
            st_q <= E_SUSP; ph_q <= 1'b1;
          end else if (cur_last) begin
            st_q <= E_IDLE; sel_q <= '0; cur_q <= '0;
          end else begin
            cur_q <= cur_q + 1'b1;
          end
        end
        E_SUSP: begin
          if (prog_ok) begin
            st_q <= E_SPROG; pa_q <= wr_idx; pd_q <= wr_data_i; cnt_q <= '0;
          end else if (add_cmd && dec_idle_i) begin
            st_q <= ph_q ? E_ERS : E_PRE;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    arr_we_o  = 1'b0;
    arr_and_o = 1'b1;
    arr_idx_o = pa_q;
    arr_d_o   = pd_q;
    case (st_q)
      E_PROG, E_SPROG: arr_we_o = prog_end;
      E_PRE: begin
        arr_we_o = sel_q[cur_sec]; arr_idx_o = cur_q; arr_d_o = 8'h00;
      end
      E_ERS: begin
        arr_we_o = sel_q[cur_sec]; arr_idx_o = cur_q; arr_d_o = 8'hFF;
        arr_and_o = 1'b0;
      end
      default: ;
    endcase
  end

  assign state_o  = st_q;
  assign sel_o    = sel_q;
  assign pd7_o    = pd_q[7];
  assign dec_en_o = (st_q == E_IDLE) || (st_q == E_SUSP);

  // R7: no stale selection survives an erase
  p_idle_no_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == E_IDLE |-> sel_q == '0);
  // R9: selection frozen while suspended
  p_susp_sel_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == E_SUSP |=> $stable(sel_q));
  // R11: protected sectors never selected (prot_i held static during operations)
  p_sel_unprot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != E_IDLE |-> (sel_q & prot_i) == '0);
endmodule

// File: rtl/flash_status.sv
module flash_status import flash_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_stb_i,
  input  eng_state_e st_i,
  input  logic       sel_hit_i,
  input  logic       pd7_i,
  input  logic [7:0] arr_q_i,
  output logic [7:0] data_o
);
  logic t6_q, t2_q, t6_n, t2_n, busy, ers_rel, stat_mode, dq7, b2;

  assign busy      = st_i inside {E_PROG, E_SPROG, E_WIN, E_PRE, E_ERS};
  assign ers_rel   = st_i inside {E_WIN, E_PRE, E_ERS, E_SUSP, E_SPROG};
  assign stat_mode = busy || (st_i == E_SUSP && sel_hit_i);
  assign t6_n      = busy ? ~t6_q : t6_q;
  assign t2_n      = (ers_rel && sel_hit_i) ? ~t2_q : t2_q;
  assign b2        = (st_i == E_PROG) ? 1'b0 : t2_n;

  always_comb begin
    case (st_i)
      E_PROG, E_SPROG: dq7 = ~pd7_i;
      E_SUSP:          dq7 = 1'b1;
      default:         dq7 = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_q   <= 1'b0;
      t2_q   <= 1'b0;
      data_o <= '0;
    end else if (rd_stb_i) begin
      t6_q   <= t6_n;
      t2_q   <= t2_n;
      data_o <= stat_mode ? {dq7, t6_n, 3'b000, b2, 2'b00} : arr_q_i;
    end
  end

  p_t6_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && busy) |=> t6_q != $past(t6_q));
  p_t6_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && st_i == E_SUSP) |=> $stable(t6_q));
  p_t2_flip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && ers_rel && sel_hit_i) |=> t2_q != $past(t2_q));
  p_zero_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && stat_mode) |=> (data_o[5:3] == 3'b000 && data_o[1:0] == 2'b00));
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl import flash_pkg::*; #(
  parameter int ADDR_W   = 19,
  parameter int SECTORS  = 8,
  parameter int OFF_W    = 6,
  parameter int PROG_CYC = 8,
  parameter int WIN_CYC  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_ni,
  input  logic               we_ni,
  input  logic               oe_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         data_i,
  input  logic [SECTORS-1:0] prot_i,
  output logic [7:0]         data_o
);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int ARR_AW = SEC_W + OFF_W;
  localparam int CA_W   = ADDR_W - SEC_W;

  logic we_q, oe_q, wr_stb, rd_stb;
  logic [SEC_W-1:0]   sec;
  logic [OFF_W-1:0]   off;
  logic [ARR_AW-1:0]  arr_idx;
  logic [7:0]         arr_d, arr_q;
  logic               arr_we, arr_and;
  logic               prog_cmd, chip_cmd, sect_cmd, dec_idle, dec_en, pd7;
  logic [SECTORS-1:0] sel;
  eng_state_e         st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni;
    end
  end

  assign wr_stb = !ce_ni && !we_q && we_ni;
  assign rd_stb = !ce_ni && oe_q && !oe_ni && we_ni;
  assign sec    = addr_i[ADDR_W-1 -: SEC_W];
  assign off    = addr_i[OFF_W-1:0];

  flash_cmd_dec #(.CA_W(CA_W)) u_dec (
    .clk_i, .rst_ni, .enable_i(dec_en), .wr_stb_i(wr_stb),
    .addr_i(addr_i[CA_W-1:0]), .data_i,
    .prog_o(prog_cmd), .chip_o(chip_cmd), .sect_o(sect_cmd), .idle_o(dec_idle)
  );

  flash_op_engine #(
    .SECTORS(SECTORS), .OFF_W(OFF_W), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC)
  ) u_eng (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .wr_data_i(data_i),
    .wr_sec_i(sec), .wr_off_i(off),
    .prog_cmd_i(prog_cmd), .chip_cmd_i(chip_cmd), .sect_cmd_i(sect_cmd),
    .dec_idle_i(dec_idle), .prot_i,
    .state_o(st), .sel_o(sel), .pd7_o(pd7), .dec_en_o(dec_en),
    .arr_we_o(arr_we), .arr_and_o(arr_and), .arr_idx_o(arr_idx), .arr_d_o(arr_d)
  );

  flash_array #(.AW(ARR_AW)) u_arr (
    .clk_i, .rst_ni, .rd_idx_i({sec, off}), .rd_o(arr_q),
    .wr_en_i(arr_we), .wr_and_i(arr_and), .wr_idx_i(arr_idx), .wr_d_i(arr_d)
  );

  flash_status u_stat (
    .clk_i, .rst_ni, .rd_stb_i(rd_stb), .st_i(st), .sel_hit_i(sel[sec]),
    .pd7_i(pd7), .arr_q_i(arr_q), .data_o
  );
endmodule

// File: tb/nor_flash_ctrl_bench.sv
module nor_flash_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  prot = '0;
  logic [7:0]  dout;

  int checks = 0;
  int errors = 0;
  logic t6 = 1'b0, t2 = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       rd_ev;

  always #4 clk = ~clk;

  nor_flash_ctrl u_nor_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .prot_i(prot), .data_o(dout)
  );

  function automatic logic [18:0] ad(input int s, input int o);
    return {3'(s), 16'(o)};
  endfunction

  function automatic logic [7:0] ex_prog(input logic [7:0] d);
    t6 = ~t6;
    return {~d[7], t6, 6'b0};
  endfunction

  function automatic logic [7:0] ex_sprog(input logic [7:0] d, input bit hit);
    t6 = ~t6;
    if (hit) t2 = ~t2;
    return {~d[7], t6, 3'b0, t2, 2'b0};
  endfunction

  function automatic logic [7:0] ex_ers(input bit hit);
    t6 = ~t6;
    if (hit) t2 = ~t2;
    return {1'b0, t6, 3'b0, t2, 2'b0};
  endfunction

  function automatic logic [7:0] ex_susp();
    t2 = ~t2;
    return {1'b1, t6, 3'b0, t2, 2'b0};
  endfunction

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); ->rd_ev; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic prog(input logic [18:0] a, input logic [7:0] d);
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_setup();
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55); wr(19'h555, 8'h80);
    wr(19'h555, 8'hAA); wr(19'h2AA, 8'h55);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops expected items as read results appear
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (dout !== e) begin
          errors++;
          $display("FAIL %s: data_o=%02h expected=%02h", t, dout, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (dout !== 8'h00) begin
      errors++;
      $display("FAIL R1: reset data_o=%02h expected=00", dout);
    end
    rd(ad(0, 0), 8'hFF, "R1");
    rd(ad(5, 17), 8'hFF, "R1");

    // R2: basic program, later protected
    prog(ad(7, 5), 8'h12);
    idle(20);
    rd(ad(7, 5), 8'h12, "R2");

    // R4/R5: polling while busy then true data
    prog(ad(1, 3), 8'h5A);
    rd(ad(1, 3), ex_prog(8'h5A), "R4");
    rd(ad(1, 3), ex_prog(8'h5A), "R5");
    idle(20);
    rd(ad(1, 3), 8'h5A, "R4");

    // R2: programming only clears bits
    prog(ad(1, 3), 8'hF0);
    idle(20);
    rd(ad(1, 3), 8'h50, "R2");

    // R3: broken unlock
    wr(19'h555, 8'hAA); wr(19'h2AB, 8'h55); wr(19'h555, 8'hA0); wr(ad(1, 3), 8'h00);
    idle(20);
    rd(ad(1, 3), 8'h50, "R3");
    // R3: abort byte mid-sequence
    wr(19'h555, 8'hAA); wr(19'h000, 8'hF0); wr(19'h2AA, 8'h55);
    wr(19'h555, 8'hA0); wr(ad(1, 3), 8'h00);
    idle(20);
    rd(ad(1, 3), 8'h50, "R3");

    // R12: sector/offset split
    prog(ad(2, 3), 8'h33); idle(20);
    prog(ad(3, 3), 8'h44); idle(20);
    rd(ad(2, 3), 8'h33, "R12");
    rd(ad(3, 3), 8'h44, "R12");
    rd(ad(2, 16'h0403), 8'h33, "R12");

    // R7: sector erase of 1, sector 2 added in window
    erase_setup();
    wr(ad(1, 0), 8'h30);
    wr(ad(2, 0), 8'h30);
    rd(ad(1, 3), ex_ers(1'b1), "R6");
    rd(ad(3, 3), ex_ers(1'b0), "R6");
    rd(ad(2, 3), ex_ers(1'b1), "R4");
    idle(40);
    // R9: suspend
    wr(19'h0, 8'hB0);
    idle(2);
    rd(ad(3, 3), 8'h44, "R9");
    rd(ad(1, 3), ex_susp(), "R9");
    rd(ad(2, 3), ex_susp(), "R6");
    // R10: program while suspended
    prog(ad(3, 3), 8'h04);
    rd(ad(3, 3), ex_sprog(8'h04, 1'b0), "R10");
    idle(20);
    rd(ad(3, 3), 8'h04, "R10");
    prog(ad(1, 3), 8'h00);
    rd(ad(3, 3), 8'h04, "R10");
    idle(20);
    // R9: resume
    wr(19'h0, 8'h30);
    rd(ad(1, 3), ex_ers(1'b1), "R9");
    idle(1100);
    rd(ad(1, 3), 8'hFF, "R7");
    rd(ad(2, 3), 8'hFF, "R7");
    rd(ad(3, 3), 8'h04, "R7");
    rd(ad(7, 5), 8'h12, "R7");

    // R11: protection
    @(negedge clk); prot = 8'h80;
    prog(ad(7, 5), 8'h00);
    rd(ad(7, 5), 8'h12, "R11");
    idle(20);
    rd(ad(7, 5), 8'h12, "R11");
    erase_setup();
    wr(ad(7, 0), 8'h30);
    rd(ad(7, 5), 8'h12, "R11");

    // R8: chip erase skips protected sector
    erase_setup();
    wr(19'h555, 8'h10);
    rd(ad(3, 3), ex_ers(1'b1), "R8");
    idle(1100);
    rd(ad(3, 3), 8'hFF, "R8");
    rd(ad(1, 3), 8'hFF, "R8");
    rd(ad(7, 5), 8'h12, "R11");

    idle(4);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule